// File: doc/BRIEF.md
# Cache-Block Operation Permission Checker

This block sits after instruction decode and rules on each cache-block management instruction: zero, clean, flush or invalidate. From the current privilege level, the virtualization bit and the enable fields of the machine, hypervisor and supervisor environment configuration registers, it decides one of three outcomes. The instruction either executes, raises an illegal-instruction trap, or raises a virtual-instruction trap. For an invalidate that executes, it also reports whether the cache performs a true invalidate or a plain flush.

Each configuration level is presented as a 4-bit field:

| Bit(s) | Meaning |
|---|---|
| 0 | Zero enable |
| 1 | Clean/flush enable |
| 3:2 | Invalidate control |

Operation codes:

| Code | Operation |
|---|---|
| 00 | zero |
| 01 | clean |
| 10 | flush |
| 11 | invalidate |

Privilege codes:

| Code | Level |
|---|---|
| 00 | user |
| 01 | supervisor |
| 11 | machine |

A request is accepted on a cycle where `req_valid` is high. The verdict appears on the registered outputs after the next rising clock edge. The checker pulls in the level fields that apply to the current mode:

- The machine field always applies below machine mode.
- The hypervisor field applies when virtualization is on.
- The supervisor field applies in user mode, whether virtual or not.

Top module: `cbo_perm_check`

## Requirements
- R1: With privilege 11 (machine), every operation executes and `res_op` equals the requested operation code, whatever the configuration fields and the virtualization bit hold.
- R2: Below machine mode, if the machine field denies the operation, the result is an illegal-instruction trap, even if other levels also deny.
- R3: A zero operation in user mode also needs supervisor bit 0. In virtual user mode it needs hypervisor bit 0 and supervisor bit 0 as well.
- R4: Clean and flush are both governed by bit 1 of each applicable level, and behave identically.
- R5: Invalidate control has four codes: 00 denies, 01 allows as a flush, 11 allows as a true invalidate, and 10 is treated as a denial. An executed invalidate reports `res_op`=11 only if every applicable level holds 11; otherwise it reports 10 (flush).
- R6: When the machine field permits, a hypervisor denial while virtualization is on gives a virtual-instruction trap. A supervisor denial gives a virtual-instruction trap in virtual user mode and an illegal-instruction trap in non-virtual user mode.
- R7: Supervisor mode without virtualization consults only the machine field.
- R8: Whenever `res_valid` is high, exactly one of `res_exec`, `res_illegal` and `res_virtual` is high. `res_op` is 00 when the operation traps.
- R9: `res_valid` rises in the cycle after a valid request and is low otherwise. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Operation code |
| req_priv | input | 2 | Current privilege |
| req_virt | input | 1 | Virtualization on |
| cfg_m | input | 4 | Machine-level enable field |
| cfg_h | input | 4 | Hypervisor-level enable field |
| cfg_s | input | 4 | Supervisor-level enable field |
| res_valid | output | 1 | Result strobe |
| res_exec | output | 1 | Operation executes |
| res_illegal | output | 1 | Illegal-instruction trap |
| res_virtual | output | 1 | Virtual-instruction trap |
| res_op | output | 2 | Effective operation code |

## Verification
The hardest outcome to reach is the one where the trap type depends on which level denied permission while several levels are involved. This happens in virtual user mode when the machine level permits but exactly one of the hypervisor or supervisor levels refuses. The same condition arises for the downgrade from invalidate to flush when only one level among three holds code 01. The stimulus sweeps every operation across every mode with each level's field set in turn to permit, deny and, for invalidate, 01, 10 and 11. This reaches each single-level refusal and each mixed invalidate combination deliberately.

// File: rtl/cbo_perm_pkg.sv
package cbo_perm_pkg;
  localparam int unsigned OP_W   = 2;
  localparam int unsigned PRIV_W = 2;
  localparam int unsigned CFG_W  = 4;
  localparam int unsigned STR_W  = 2;
  localparam int unsigned NUM_LVL = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ZERO  = 2'b00,
    OP_CLEAN = 2'b01,
    OP_FLUSH = 2'b10,
    OP_INVAL = 2'b11
  } cbo_op_e;

  typedef enum logic [PRIV_W-1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_R = 2'b10,
    PRIV_M = 2'b11
  } priv_e;

  // Permission strength granted by one level: none < flush-only < full
  typedef enum logic [STR_W-1:0] {
    STR_NONE  = 2'd0,
    STR_FLUSH = 2'd1,
    STR_FULL  = 2'd2
  } grant_e;

  localparam int unsigned LVL_M = 0;
  localparam int unsigned LVL_H = 1;
  localparam int unsigned LVL_S = 2;
endpackage

// File: rtl/cbo_level_grant.sv
module cbo_level_grant
  import cbo_perm_pkg::*;
(
  input  logic [OP_W-1:0]  op,
  input  logic [CFG_W-1:0] cfg,
  output logic [STR_W-1:0] grant
);
  logic zero_en, cf_en;
  logic [1:0] inv_ctl;

  assign zero_en = cfg[0];
  assign cf_en   = cfg[1];
  assign inv_ctl = cfg[3:2];

  always_comb begin
    grant = STR_NONE;
    unique case (cbo_op_e'(op))
      OP_ZERO:            grant = zero_en ? STR_FULL : STR_NONE;
      OP_CLEAN, OP_FLUSH: grant = cf_en ? STR_FULL : STR_NONE;
      OP_INVAL: begin
        unique case (inv_ctl)
          2'b01:   grant = STR_FLUSH;
          2'b11:   grant = STR_FULL;
          default: grant = STR_NONE;
        endcase
      end
      default: grant = STR_NONE;
    endcase
  end
endmodule

// File: rtl/cbo_perm_decide.sv
module cbo_perm_decide
  import cbo_perm_pkg::*;
(
  input  logic [OP_W-1:0]          op,
  input  logic [PRIV_W-1:0]        priv,
  input  logic                     virt,
  input  logic [NUM_LVL*STR_W-1:0] grants,
  output logic                     do_exec,
  output logic                     do_illegal,
  output logic                     do_virtual,
  output logic [OP_W-1:0]          eff_op
);
  logic [STR_W-1:0] g_m, g_h, g_s, weakest;
  logic is_mach, h_applies, s_applies;

  assign g_m = grants[LVL_M*STR_W +: STR_W];
  assign g_h = grants[LVL_H*STR_W +: STR_W];
  assign g_s = grants[LVL_S*STR_W +: STR_W];

  assign is_mach   = (priv == PRIV_M);
  assign h_applies = !is_mach && virt;
  assign s_applies = (priv == PRIV_U);

  always_comb begin
    weakest = g_m;
    if (h_applies && (g_h < weakest)) weakest = g_h;
    if (s_applies && (g_s < weakest)) weakest = g_s;
  end

  always_comb begin
    do_exec    = 1'b0;
    do_illegal = 1'b0;
    do_virtual = 1'b0;
    eff_op     = OP_ZERO;
    if (is_mach) begin
      do_exec = 1'b1;
      eff_op  = op;
    end else if (g_m == STR_NONE) begin
      do_illegal = 1'b1;
    end else if (h_applies && (g_h == STR_NONE)) begin
      do_virtual = 1'b1;
    end else if (s_applies && (g_s == STR_NONE)) begin
      if (virt) do_virtual = 1'b1;
      else      do_illegal = 1'b1;
    end else begin
      do_exec = 1'b1;
      if (cbo_op_e'(op) == OP_INVAL && weakest == STR_FLUSH) eff_op = OP_FLUSH;
      else                                                  eff_op = op;
    end
  end
endmodule

// File: rtl/cbo_perm_check.sv
module cbo_perm_check
  import cbo_perm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [OP_W-1:0]   req_op,
  input  logic [PRIV_W-1:0] req_priv,
  input  logic              req_virt,
  input  logic [CFG_W-1:0]  cfg_m,
  input  logic [CFG_W-1:0]  cfg_h,
  input  logic [CFG_W-1:0]  cfg_s,
  output logic              res_valid,
  output logic              res_exec,
  output logic              res_illegal,
  output logic              res_virtual,
  output logic [OP_W-1:0]   res_op
);
  logic [NUM_LVL*CFG_W-1:0] cfg_all;
  logic [NUM_LVL*STR_W-1:0] grants;
  logic n_exec, n_illegal, n_virtual;
  logic [OP_W-1:0] n_op;

  assign cfg_all = {cfg_s, cfg_h, cfg_m};

  for (genvar lv = 0; lv < NUM_LVL; lv++) begin : g_level
    cbo_level_grant u_grant (
      .op    (req_op),
      .cfg   (cfg_all[lv*CFG_W +: CFG_W]),
      .grant (grants[lv*STR_W +: STR_W])
    );
  end

  cbo_perm_decide u_decide (
    .op         (req_op),
    .priv       (req_priv),
    .virt       (req_virt),
    .grants     (grants),
    .do_exec    (n_exec),
    .do_illegal (n_illegal),
    .do_virtual (n_virtual),
    .eff_op     (n_op)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_valid <= 1'b0;
    else        res_valid <= req_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_exec    <= 1'b0;
      res_illegal <= 1'b0;
      res_virtual <= 1'b0;
      res_op      <= '0;
    end else if (req_valid) begin
      res_exec    <= n_exec;
      res_illegal <= n_illegal;
      res_virtual <= n_virtual;
      res_op      <= n_op;
    end
  end
endmodule

// File: rtl/cbo_perm_check_sva.sv
module cbo_perm_check_sva
  import cbo_perm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [OP_W-1:0]   req_op,
  input logic [PRIV_W-1:0] req_priv,
  input logic              req_virt,
  input logic [CFG_W-1:0]  cfg_m,
  input logic              res_valid,
  input logic              res_exec,
  input logic              res_illegal,
  input logic              res_virtual,
  input logic [OP_W-1:0]   res_op
);
  assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $countones({res_exec, res_illegal, res_virtual}) == 1);

  assert_trap_op_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_exec) |-> res_op == '0);

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);

  assert_valid_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);

  assert_machine_exec_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_priv == PRIV_M) |=> (res_exec && res_op == $past(req_op)));

  assert_mzero_illegal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_priv != PRIV_M && req_op == OP_ZERO && !cfg_m[0]) |=> res_illegal);

  assert_virtual_needs_virt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_virt) |=> !res_virtual);

  assert_inval_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op != OP_INVAL) |=> res_op != OP_INVAL);
endmodule

bind cbo_perm_check cbo_perm_check_sva u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_op      (req_op),
  .req_priv    (req_priv),
  .req_virt    (req_virt),
  .cfg_m       (cfg_m),
  .res_valid   (res_valid),
  .res_exec    (res_exec),
  .res_illegal (res_illegal),
  .res_virtual (res_virtual),
  .res_op      (res_op)
);

// File: tb/cbo_perm_check_test.sv
module cbo_perm_check_test;
  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic [1:0] req_op;
  logic [1:0] req_priv;
  logic       req_virt;
  logic [3:0] cfg_m, cfg_h, cfg_s;
  logic       res_valid, res_exec, res_illegal, res_virtual;
  logic [1:0] res_op;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct packed {
    logic [2:0] flags;   // {exec, illegal, virtual}
    logic [1:0] op;
    logic [7:0] tag;     // requirement number being exercised
  } exp_t;
  exp_t q[$];

  cbo_perm_check uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_priv(req_priv), .req_virt(req_virt), .cfg_m(cfg_m), .cfg_h(cfg_h),
    .cfg_s(cfg_s), .res_valid(res_valid), .res_exec(res_exec),
    .res_illegal(res_illegal), .res_virtual(res_virtual), .res_op(res_op)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  // Level rank from requirements: 0 refused, 1 flush-only, 2 full
  function automatic int rank(input logic [1:0] op, input logic [3:0] f);
    if (op == 2'b00) return f[0] ? 2 : 0;
    if (op == 2'b11) return (f[3:2] == 2'b11) ? 2 : (f[3:2] == 2'b01) ? 1 : 0;
    return f[1] ? 2 : 0;
  endfunction

  function automatic exp_t model(input logic [1:0] op, input logic [1:0] pv,
                                 input logic vt, input logic [3:0] m,
                                 input logic [3:0] h, input logic [3:0] s,
                                 input logic [7:0] tag);
    exp_t e;
    int rm, rh, rs, lo;
    e.tag = tag;
    e.op = 2'b00;
    rm = rank(op, m); rh = rank(op, h); rs = rank(op, s);
    if (pv == 2'b11) begin
      e.flags = 3'b100; e.op = op; return e;
    end
    lo = rm;
    if (vt && rh < lo) lo = rh;
    if (pv == 2'b00 && rs < lo) lo = rs;
    if (rm == 0)                    e.flags = 3'b010;
    else if (vt && rh == 0)         e.flags = 3'b001;
    else if (pv == 2'b00 && rs == 0) e.flags = vt ? 3'b001 : 3'b010;
    else begin
      e.flags = 3'b100;
      e.op = (op == 2'b11 && lo == 1) ? 2'b10 : op;
    end
    return e;
  endfunction

  task automatic send(input logic [1:0] op, input logic [1:0] pv, input logic vt,
                      input logic [3:0] m, input logic [3:0] h, input logic [3:0] s,
                      input logic [7:0] tag);
    @(negedge clk);
    req_valid = 1; req_op = op; req_priv = pv; req_virt = vt;
    cfg_m = m; cfg_h = h; cfg_s = s;
    q.push_back(model(op, pv, vt, m, h, s, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 0;
  endtask

  // Monitor: results appear one edge after the request
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      exp_t e;
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R9: unexpected res_valid, act=1 exp=0");
      end else begin
        e = q.pop_front();
        if ({res_exec, res_illegal, res_virtual} != e.flags || res_op != e.op) begin
          errors++;
          $display("FAIL R%0d: act flags=%b op=%b exp flags=%b op=%b",
                   e.tag, {res_exec, res_illegal, res_virtual}, res_op, e.flags, e.op);
        end
      end
    end else if (rst_n && !res_valid && q.size() > 1) begin
      checks++;
      errors++;
      $display("FAIL R9: res_valid act=0 exp=1");
    end
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: act=timeout exp=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_op = 0; req_priv = 0; req_virt = 0;
    cfg_m = 0; cfg_h = 0; cfg_s = 0;
    repeat (3) @(negedge clk);
    checks++;
    if ({res_valid, res_exec, res_illegal, res_virtual, res_op} != 0) begin
      errors++;
      $display("FAIL R9: reset outputs act=%b exp=0",
               {res_valid, res_exec, res_illegal, res_virtual, res_op});
    end
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (res_valid !== 1'b0) begin
      errors++; $display("FAIL R9: idle res_valid act=%b exp=0", res_valid);
    end

    // R1: machine mode executes with everything off, virt bit set too
    send(2'b11, 2'b11, 1'b1, 4'h0, 4'h0, 4'h0, 8'd1);
    send(2'b00, 2'b11, 1'b0, 4'h0, 4'h0, 4'h0, 8'd1);
    // R2: machine denial wins over other denials
    send(2'b01, 2'b00, 1'b1, 4'h0, 4'h0, 4'h0, 8'd2);
    // R3: zero in U and VU
    send(2'b00, 2'b00, 1'b0, 4'h1, 4'h0, 4'h1, 8'd3);
    send(2'b00, 2'b00, 1'b1, 4'h1, 4'h0, 4'h1, 8'd3);
    send(2'b00, 2'b00, 1'b1, 4'h1, 4'h1, 4'h0, 8'd3);
    // R4: clean and flush share bit 1
    send(2'b01, 2'b00, 1'b0, 4'h2, 4'h0, 4'h2, 8'd4);
    send(2'b10, 2'b00, 1'b0, 4'h2, 4'h0, 4'h1, 8'd4);
    // R5: invalidate downgrade and reserved code
    send(2'b11, 2'b00, 1'b1, 4'hC, 4'h4, 4'hC, 8'd5);
    send(2'b11, 2'b00, 1'b1, 4'hC, 4'hC, 4'hC, 8'd5);
    send(2'b11, 2'b01, 1'b0, 4'h8, 4'h0, 4'h0, 8'd5);
    // R6: hypervisor denial in VS, supervisor denial in U
    send(2'b01, 2'b01, 1'b1, 4'h2, 4'h0, 4'h0, 8'd6);
    send(2'b11, 2'b00, 1'b0, 4'hC, 4'hC, 4'h0, 8'd6);
    // R7: non-virtual S ignores h and s fields
    send(2'b11, 2'b01, 1'b0, 4'h4, 4'h0, 4'h0, 8'd7);
    idle();
    idle();
    // R8: full sweep, every op/mode with per-level field choices
    for (int op = 0; op < 4; op++)
      for (int md = 0; md < 5; md++)
        for (int fm = 0; fm < 4; fm++)
          for (int fh = 0; fh < 4; fh++)
            for (int fs = 0; fs < 4; fs++) begin
              logic [1:0] pv;
              logic vt;
              logic [3:0] vm, vh, vs;
              pv = (md == 0 || md == 3) ? 2'b00 : (md == 1 || md == 4) ? 2'b01 : 2'b11;
              vt = (md >= 3);
              vm = {fm[1:0], fm[0], fm[0]};
              vh = {fh[1:0], fh[0], fh[0]};
              vs = {fs[1:0], fs[0], fs[0]};
              send(op[1:0], pv, vt, vm, vh, vs, 8'd8);
            end
    idle();
    idle();
    idle();
    // R9: nothing pending, no strobe
    checks++;
    if (res_valid !== 1'b0 || q.size() != 0) begin
      errors++;
      $display("FAIL R9: trailing res_valid act=%b exp=0 pending=%0d", res_valid, q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule